// File: doc/BRIEF.md
# Dual-Channel Successive-Approximation Converter Sequencer

This block is the digital control of a 7-bit successive-approximation converter shared by two analog inputs: a signal-strength level (channel 0) and a multipath-distortion level (channel 1). It drives a channel select and a trial code to an external DAC and comparator. It reads back one comparator bit per trial and resolves both channels, one after the other, inside a fixed frame of 1968 clocks. At a 61.5 MHz reference clock that frame is 32 µs.

Three configuration bits control it: an enable, a mode bit that picks single-shot or free-running operation, and a start bit that counts only when a register write strobe accompanies it. At the end of each frame both 7-bit codes are written at once into a 16-bit result word, and a one-clock done pulse is raised. The comparator, the DAC and the bus that reads the result lie outside the block.

Top module: `adc_pair_seq`

## Requirements
- R1: While reset is held and after it is released with no command, `busy_o`, `done_o`, `ch_sel_o`, `dac_code_o` and `result_o` are all zero.
- R2: A write strobe (`cfg_wr`=1) with `cfg_en`=1, `cfg_cont`=0 and `cfg_start`=1 while idle starts a conversion pair at that clock edge. `done_o` is high for exactly one cycle, FRAME_CLKS (1968) clock edges after the launching edge.
- R3: Channel 0 (`ch_sel_o`=0) is converted first, then channel 1. Each channel runs 7 trials starting at the MSB, so the first trial code is 0x40. Each trial lasts SETTLE_CLKS (140) clocks. A trial bit is kept when `cmp_i`=1, which means input ≥ trial code. After the 7th trial of channel 0, `ch_sel_o` becomes 1 and the code returns to 0x40.
- R4: With a comparator that compares input ≥ code, each channel's result equals its input code exactly, including the extremes 0 and 127.
- R5: `result_o` holds channel 1 in bits 14..8 and channel 0 in bits 6..0, with bits 15 and 7 zero. It changes only in the cycle in which `done_o` is high.
- R6: In single mode, no further pair runs after one completes until the start write is repeated. A write with `cfg_start`=0 launches nothing.
- R7: Writes made while a pair is in progress are ignored: they neither restart nor lengthen the frame.
- R8: With `cfg_en`=1 and `cfg_cont`=1, pairs run back to back with no writes, and `done_o` pulses every 1968 clocks. Each result reflects the inputs present during its frame. Clearing `cfg_cont` lets the running pair finish and then stops.
- R9: With `cfg_en`=0 no pair starts in either mode. Clearing `cfg_en` during a pair aborts it at the next edge, with no done pulse and `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (reference clock) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Converter enable |
| cfg_cont | input | 1 | 1 = free-running, 0 = single-shot |
| cfg_start | input | 1 | Start request, taken only with `cfg_wr` |
| cfg_wr | input | 1 | One-cycle strobe marking a control register write |
| cmp_i | input | 1 | Comparator: 1 when the selected input ≥ trial code |
| ch_sel_o | output | 1 | Analog channel select (0 = signal strength, 1 = multipath) |
| dac_code_o | output | 7 | Trial code driven to the DAC |
| busy_o | output | 1 | A conversion frame is running |
| done_o | output | 1 | One-cycle pulse when `result_o` has been updated |
| result_o | output | 16 | Packed result word |

## Verification
If the launching edge is t0, the done pulse and the new result word are due at the negative edge following edge t0+1968. Each trial code holds from edge t0+140·k to edge t0+140·(k+1). The driver task records t0 from its own edge counter and queues each expected word together with that due edge. The monitor compares the cycle number at which `done_o` is seen against the queued edge, as well as the word. Trial codes and the channel switch are sampled 5 cycles into a trial window, away from any transition. Every "nothing happens" case is checked after at least one full frame of waiting, by looking at the done count, `busy_o` and `result_o`.

// File: rtl/adc_pair_pkg.sv
package adc_pair_pkg;
  // number of multiplexed analog inputs converted in one frame
  localparam int ADC_CHANNELS = 2;

  // width of the packed result: each channel takes RES_BITS plus a zero pad bit
  function automatic int packed_width(int res_bits);
    return ADC_CHANNELS * (res_bits + 1);
  endfunction
endpackage

// File: rtl/adc_pair_timer.sv
module adc_pair_timer #(
  parameter int FRAME_CLKS  = 1968,
  parameter int SETTLE_CLKS = 140
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic trial_tick,
  output logic frame_end
);
  localparam int FRAME_W = $clog2(FRAME_CLKS);
  localparam int SETTLE_W = $clog2(SETTLE_CLKS);
  localparam logic [FRAME_W-1:0]  LAST_F = FRAME_W'(FRAME_CLKS - 1);
  localparam logic [SETTLE_W-1:0] LAST_S = SETTLE_W'(SETTLE_CLKS - 1);

  logic [FRAME_W-1:0]  frame_cnt;
  logic [SETTLE_W-1:0] settle_cnt;

  assign frame_end  = run && (frame_cnt == LAST_F);
  assign trial_tick = run && (settle_cnt == LAST_S);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      frame_cnt  <= '0;
      settle_cnt <= '0;
    end else if (run) begin
      frame_cnt  <= frame_end ? '0 : frame_cnt + 1'b1;
      settle_cnt <= trial_tick ? '0 : settle_cnt + 1'b1;
    end
  end

  // R2
  frame_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (frame_cnt <= LAST_F));
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
  import adc_pair_pkg::*;
#(
  parameter int RES_BITS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic tick,
  input  logic cmp,
  output logic [RES_BITS-1:0] code,
  output logic ch,
  output logic [ADC_CHANNELS-1:0][RES_BITS-1:0] res
);
  localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] mask;
  logic [RES_BITS-1:0] kept;
  logic active;
  logic last_trial;

  // keep the trial bit when the input is at or above the trial level
  assign kept = cmp ? code : (code & ~mask);
  assign last_trial = tick && active && mask[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= '0;
      mask   <= '0;
      ch     <= 1'b0;
      active <= 1'b0;
    end else if (abort) begin
      code   <= '0;
      mask   <= '0;
      active <= 1'b0;
    end else if (start) begin
      code   <= MSB_ONE;
      mask   <= MSB_ONE;
      ch     <= 1'b0;
      active <= 1'b1;
    end else if (tick && active) begin
      if (mask[0]) begin
        if (ch) begin
          code   <= '0;
          mask   <= '0;
          active <= 1'b0;
        end else begin
          ch   <= 1'b1;
          code <= MSB_ONE;
          mask <= MSB_ONE;
        end
      end else begin
        mask <= mask >> 1;
        code <= kept | (mask >> 1);
      end
    end
  end

  for (genvar g = 0; g < ADC_CHANNELS; g++) begin : g_chan_res
    always_ff @(posedge clk) begin
      if (rst) res[g] <= '0;
      else if (!abort && last_trial && (ch == 1'(g))) res[g] <= kept;
    end
  end

  // R3
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !abort) |=> (code == MSB_ONE && !ch));
endmodule

// File: rtl/adc_result_pack.sv
module adc_result_pack
  import adc_pair_pkg::*;
#(
  parameter int RES_BITS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic latch,
  input  logic [ADC_CHANNELS-1:0][RES_BITS-1:0] res,
  output logic [packed_width(RES_BITS)-1:0] result,
  output logic done
);
  localparam int SLOT = RES_BITS + 1;

  logic [packed_width(RES_BITS)-1:0] word;

  for (genvar g = 0; g < ADC_CHANNELS; g++) begin : g_slot
    assign word[g*SLOT +: SLOT] = {1'b0, res[g]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= latch;
      if (latch) result <= word;
    end
  end

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/adc_pair_seq.sv
module adc_pair_seq
  import adc_pair_pkg::*;
#(
  parameter int RES_BITS    = 7,
  parameter int FRAME_CLKS  = 1968,
  parameter int SETTLE_CLKS = 140
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_en,
  input  logic cfg_cont,
  input  logic cfg_start,
  input  logic cfg_wr,
  input  logic cmp_i,
  output logic ch_sel_o,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic busy_o,
  output logic done_o,
  output logic [packed_width(RES_BITS)-1:0] result_o
);
  logic busy;
  logic launch, relaunch, start, abort;
  logic trial_tick, frame_end;
  logic [ADC_CHANNELS-1:0][RES_BITS-1:0] chan_res;

  assign launch   = !busy && cfg_en && (cfg_cont || (cfg_wr && cfg_start));
  assign relaunch = frame_end && cfg_en && cfg_cont;
  assign start    = launch || relaunch;
  assign abort    = !cfg_en;

  always_ff @(posedge clk) begin
    if (rst || abort) busy <= 1'b0;
    else if (start)   busy <= 1'b1;
    else if (frame_end) busy <= 1'b0;
  end

  adc_pair_timer #(
    .FRAME_CLKS (FRAME_CLKS),
    .SETTLE_CLKS(SETTLE_CLKS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .run       (busy),
    .trial_tick(trial_tick),
    .frame_end (frame_end)
  );

  adc_sar_engine #(.RES_BITS(RES_BITS)) u_sar (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .abort(abort),
    .tick (trial_tick),
    .cmp  (cmp_i),
    .code (dac_code_o),
    .ch   (ch_sel_o),
    .res  (chan_res)
  );

  adc_result_pack #(.RES_BITS(RES_BITS)) u_pack (
    .clk   (clk),
    .rst   (rst),
    .latch (frame_end && cfg_en),
    .res   (chan_res),
    .result(result_o),
    .done  (done_o)
  );

  assign busy_o = busy;

  // R9
  disable_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (!busy_o && !done_o));
  // R6
  single_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !cfg_cont) |=> !busy_o);
  // R8
  cont_run_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && cfg_en && cfg_cont) |=> (busy_o && done_o));
endmodule

// File: tb/adc_pair_seq_tb.sv
module adc_pair_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 1968;
  localparam int SETTLE = 140;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, cont = 1'b0, start = 1'b0, wr = 1'b0;
  logic cmp, ch;
  logic [6:0] code;
  logic busy, done;
  logic [15:0] result;
  logic [6:0] vin_fs = '0, vin_mp = '0;

  adc_pair_seq u_dut (
    .clk(clk), .rst(rst), .cfg_en(en), .cfg_cont(cont), .cfg_start(start),
    .cfg_wr(wr), .cmp_i(cmp), .ch_sel_o(ch), .dac_code_o(code),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  // comparator and DAC model
  assign cmp = ((ch ? vin_mp : vin_fs) >= code);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_done = 0;
  logic [15:0] exp_q[$];
  int due_q[$];
  logic done_prev = 1'b0;
  logic [15:0] mon_w;
  int mon_d;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      n_done++;
      if (done_prev) check(1'b0, "R2 done wider than one cycle", 32'd1, 32'd0);
      else if (exp_q.size() == 0) check(1'b0, "R6/R9 unexpected done", 32'(result), 32'd0);
      else begin
        mon_w = exp_q.pop_front();
        mon_d = due_q.pop_front();
        check(result == mon_w, "R4 R5 result word", 32'(result), 32'(mon_w));
        check(cyc == mon_d, "R2 R8 done cycle", 32'(cyc), 32'(mon_d));
      end
    end
    done_prev <= done;
  end

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push_exp(input logic [6:0] fs, input logic [6:0] mp, input int due);
    exp_q.push_back({1'b0, mp, 1'b0, fs});
    due_q.push_back(due);
  endtask

  // driver: single-shot start write; called at a negedge
  task automatic launch(input logic [6:0] fs, input logic [6:0] mp, input bit expect_done,
                        output int t0);
    vin_fs = fs; vin_mp = mp;
    en = 1'b1; cont = 1'b0; start = 1'b1; wr = 1'b1;
    t0 = cyc + 1;
    if (expect_done) push_exp(fs, mp, t0 + FRAME);
    @(negedge clk);
    wr = 1'b0; start = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R2 watchdog expired", 32'(cyc), 32'd0);
    finish_run();
  end

  initial begin
    int t0;
    int keep_done;
    logic [15:0] keep_res;

    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy in reset", 32'(busy), 0);
    check(done == 1'b0, "R1 done in reset", 32'(done), 0);
    check(result == 16'h0, "R1 result in reset", 32'(result), 0);
    check(code == 7'h0, "R1 code in reset", 32'(code), 0);
    check(ch == 1'b0, "R1 ch_sel in reset", 32'(ch), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && result == 16'h0, "R1 idle after reset", 32'(busy), 0);

    // single pair, trial sequence, R7 write while busy
    launch(7'h55, 7'h2A, 1'b1, t0);
    wait_until(t0 + 5);
    check(busy == 1'b1, "R2 busy after launch", 32'(busy), 1);
    check(ch == 1'b0, "R3 channel 0 first", 32'(ch), 0);
    check(code == 7'h40, "R3 MSB trial first", 32'(code), 32'h40);
    wait_until(t0 + 100);
    start = 1'b1; wr = 1'b1;   // R7 ignored write
    @(negedge clk);
    wr = 1'b0; start = 1'b0;
    wait_until(t0 + SETTLE + 5);
    check(code == 7'h60, "R3 second trial code", 32'(code), 32'h60);
    wait_until(t0 + 7*SETTLE + 5);
    check(ch == 1'b1, "R3 switch to channel 1", 32'(ch), 1);
    check(code == 7'h40, "R3 channel 1 MSB trial", 32'(code), 32'h40);
    wait_until(t0 + FRAME + 2);
    check(exp_q.size() == 0, "R2 pair completed", 32'(exp_q.size()), 0);
    check(n_done == 1, "R7 single done despite busy write", 32'(n_done), 1);

    // R4 extremes
    launch(7'h00, 7'h7F, 1'b1, t0);
    wait_until(t0 + FRAME + 2);
    launch(7'h7F, 7'h00, 1'b1, t0);
    wait_until(t0 + FRAME + 2);
    check(exp_q.size() == 0, "R4 extreme codes done", 32'(exp_q.size()), 0);

    // R6 no rerun without a new write; start=0 write launches nothing
    keep_done = n_done; keep_res = result;
    wait_until(cyc + 2*FRAME);
    check(n_done == keep_done, "R6 no rerun in single mode", 32'(n_done), 32'(keep_done));
    check(busy == 1'b0, "R6 idle in single mode", 32'(busy), 0);
    en = 1'b1; cont = 1'b0; start = 1'b0; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    check(busy == 1'b0, "R6 start=0 write not launched", 32'(busy), 0);
    wait_until(cyc + FRAME + 10);
    check(n_done == keep_done && result == keep_res, "R6 no done after start=0",
          32'(n_done), 32'(keep_done));

    // R9 disabled
    en = 1'b0; start = 1'b1; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; start = 1'b0;
    check(busy == 1'b0, "R9 start write while disabled", 32'(busy), 0);
    launch(7'h33, 7'h44, 1'b0, t0);
    wait_until(t0 + 500);
    en = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R9 abort within one clock", 32'(busy), 0);
    wait_until(t0 + FRAME + 20);
    check(n_done == keep_done, "R9 no done after abort", 32'(n_done), 32'(keep_done));
    check(result == keep_res, "R9 result kept after abort", 32'(result), 32'(keep_res));

    // R8 continuous mode
    vin_fs = 7'h11; vin_mp = 7'h70;
    en = 1'b1; cont = 1'b1;
    t0 = cyc + 1;
    push_exp(7'h11, 7'h70, t0 + FRAME);
    @(negedge clk);
    wait_until(t0 + FRAME);
    vin_fs = 7'h7F; vin_mp = 7'h01;
    push_exp(7'h7F, 7'h01, t0 + 2*FRAME);
    wait_until(t0 + 2*FRAME);
    vin_fs = 7'h40; vin_mp = 7'h3F;
    push_exp(7'h40, 7'h3F, t0 + 3*FRAME);
    wait_until(t0 + 2*FRAME + 10);
    cont = 1'b0;
    wait_until(t0 + 3*FRAME + 2);
    check(busy == 1'b0, "R8 stop after running pair", 32'(busy), 0);
    check(exp_q.size() == 0, "R8 all continuous frames done", 32'(exp_q.size()), 0);
    keep_done = n_done;
    wait_until(cyc + FRAME + 10);
    check(n_done == keep_done, "R8 no frame after cont cleared", 32'(n_done), 32'(keep_done));

    check(exp_q.size() == 0, "R2 nothing pending", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule